// File: doc/BRIEF.md
# Rename Table with Result Writeback

This block holds the architectural register values of a tag-based out-of-order core together with the record of which in-flight station will produce each register next. In the issue cycle an instruction presents two source register indices and gets back, for each, either a ready value or the tag of the station it must wait on. In that same cycle the instruction's destination register is rebound to the tag of the station it was given.

The block also watches the shared result bus. When a result appears whose tag is still the newest binding of some register, the value is written into that register and the binding is dropped. A result from a producer that has since been superseded changes nothing. Because each new write gets a fresh tag, later readers follow only the latest writer, and earlier readers keep the tag they already received. This removes write-after-read and write-after-write stalls.

Tag code 0 is reserved and means "value ready, no producer pending". Station tags are therefore 1 to 15.

Top module: `rename_table`

## Requirements
- R1: After reset every register reads back as ready: tag 0 and value 0.
- R2: A lookup of a register with no pending producer returns its stored value with tag 0.
- R3: A lookup of a register with a pending producer returns that producer's tag, with the data output driven to 0.
- R4: An issue with a nonzero tag binds the destination register to that tag from the next cycle onward.
- R5: A second issue to the same register replaces the binding, so later readers see the newer tag. A reader issued between the two writers was already given the older tag.
- R6: When a looked-up register is bound to the tag on the result bus in that same cycle, the lookup returns the bus value with tag 0.
- R7: A result whose tag equals a register's current binding writes the value and leaves the register ready. A result carrying tag 0 writes nothing.
- R8: A result whose tag is no longer the register's binding leaves both the value and the binding unchanged.
- R9: When a source index equals the destination of the same issue, the lookup uses the binding from before that issue's rename.
- R10: When a rename and a matching result hit the same register in one cycle, the new binding is kept.
- R11: An issue that carries tag 0 changes no binding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | An instruction issues this cycle |
| iss_dst | input | 4 | Destination register index |
| iss_tag | input | 4 | Tag of the station given to the instruction |
| iss_src_a | input | 4 | First source register index |
| iss_src_b | input | 4 | Second source register index |
| src_a_data | output | 32 | First source value (0 while waiting) |
| src_a_tag | output | 4 | First source producer tag, 0 when ready |
| src_b_data | output | 32 | Second source value (0 while waiting) |
| src_b_tag | output | 4 | Second source producer tag, 0 when ready |
| cdb_valid | input | 1 | A result is broadcast this cycle |
| cdb_tag | input | 4 | Tag of the broadcasting station |
| cdb_data | input | 32 | Broadcast result value |

## Verification
The bench targets three points where a design can go wrong.

The first is the stale result: a producer whose register has since been renamed broadcasts its value. A design that matched on register index, or ignored the tag comparison, would overwrite the newer pending binding and release readers too early.

The second is the same-cycle collision of a rename with a matching result on one register. Here a design that let the result win would mark the register ready and lose the new producer.

The third covers the same-cycle cases: the bypass of a bus value into a lookup, and a source equal to its own destination. Without the bypass, a consumer would be handed a tag that is never broadcast again and would wait forever. A design that applied the rename before the lookup would make an instruction wait on itself.

// File: rtl/rat_pkg.sv
package rat_pkg;
    localparam int unsigned DEF_REG_CNT = 16;
    localparam int unsigned DEF_DATA_W  = 32;
    localparam int unsigned DEF_TAG_W   = 4;
    // tag code that marks a register as ready
    localparam int unsigned IDLE_TAG    = 0;
endpackage

// File: rtl/rat_lookup.sv
module rat_lookup
    import rat_pkg::*;
#(
    parameter int unsigned REG_CNT = DEF_REG_CNT,
    parameter int unsigned DATA_W  = DEF_DATA_W,
    parameter int unsigned TAG_W   = DEF_TAG_W,
    localparam int unsigned IDX_W  = $clog2(REG_CNT)
) (
    input  logic [REG_CNT-1:0][DATA_W-1:0] tbl_data,
    input  logic [REG_CNT-1:0][TAG_W-1:0]  tbl_tag,
    input  logic [IDX_W-1:0]               sel,
    input  logic                           cdb_valid,
    input  logic [TAG_W-1:0]               cdb_tag,
    input  logic [DATA_W-1:0]              cdb_data,
    output logic [DATA_W-1:0]              rd_data,
    output logic [TAG_W-1:0]               rd_tag
);
    localparam logic [TAG_W-1:0] IDLE = TAG_W'(IDLE_TAG);

    logic [TAG_W-1:0] cur_tag;

    always_comb begin
        cur_tag = tbl_tag[sel];
        rd_data = '0;
        rd_tag  = cur_tag;
        if (cur_tag == IDLE) begin
            rd_data = tbl_data[sel];
        end else if (cdb_valid && cdb_tag == cur_tag) begin
            // producer is broadcasting right now: forward its value
            rd_data = cdb_data;
            rd_tag  = IDLE;
        end
    end
endmodule

// File: rtl/rat_store.sv
module rat_store
    import rat_pkg::*;
#(
    parameter int unsigned REG_CNT = DEF_REG_CNT,
    parameter int unsigned DATA_W  = DEF_DATA_W,
    parameter int unsigned TAG_W   = DEF_TAG_W,
    localparam int unsigned IDX_W  = $clog2(REG_CNT)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           iss_valid,
    input  logic [IDX_W-1:0]               iss_dst,
    input  logic [TAG_W-1:0]               iss_tag,
    input  logic                           cdb_valid,
    input  logic [TAG_W-1:0]               cdb_tag,
    input  logic [DATA_W-1:0]              cdb_data,
    output logic [REG_CNT-1:0][DATA_W-1:0] tbl_data,
    output logic [REG_CNT-1:0][TAG_W-1:0]  tbl_tag
);
    localparam logic [TAG_W-1:0] IDLE = TAG_W'(IDLE_TAG);

    typedef struct packed {
        logic [REG_CNT-1:0][DATA_W-1:0] data;
        logic [REG_CNT-1:0][TAG_W-1:0]  tag;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int r = 0; r < REG_CNT; r++) begin
            // writeback only when the broadcast tag is still the newest binding
            if (cdb_valid && cdb_tag != IDLE && st_q.tag[r] == cdb_tag) begin
                st_d.data[r] = cdb_data;
                st_d.tag[r]  = IDLE;
            end
            // a rename in the same cycle takes precedence over the release
            if (iss_valid && iss_tag != IDLE && iss_dst == IDX_W'(r)) begin
                st_d.tag[r] = iss_tag;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tbl_data = st_q.data;
    assign tbl_tag  = st_q.tag;
endmodule

// File: rtl/rename_table.sv
module rename_table
    import rat_pkg::*;
#(
    parameter int unsigned REG_CNT = DEF_REG_CNT,
    parameter int unsigned DATA_W  = DEF_DATA_W,
    parameter int unsigned TAG_W   = DEF_TAG_W,
    localparam int unsigned IDX_W  = $clog2(REG_CNT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iss_valid,
    input  logic [IDX_W-1:0]  iss_dst,
    input  logic [TAG_W-1:0]  iss_tag,
    input  logic [IDX_W-1:0]  iss_src_a,
    input  logic [IDX_W-1:0]  iss_src_b,
    output logic [DATA_W-1:0] src_a_data,
    output logic [TAG_W-1:0]  src_a_tag,
    output logic [DATA_W-1:0] src_b_data,
    output logic [TAG_W-1:0]  src_b_tag,
    input  logic              cdb_valid,
    input  logic [TAG_W-1:0]  cdb_tag,
    input  logic [DATA_W-1:0] cdb_data
);
    localparam int unsigned SRC_PORTS = 2;

    logic [REG_CNT-1:0][DATA_W-1:0] tbl_data;
    logic [REG_CNT-1:0][TAG_W-1:0]  tbl_tag;
    logic [SRC_PORTS-1:0][IDX_W-1:0]  sel;
    logic [SRC_PORTS-1:0][DATA_W-1:0] rd_data;
    logic [SRC_PORTS-1:0][TAG_W-1:0]  rd_tag;

    rat_store #(.REG_CNT(REG_CNT), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .iss_valid (iss_valid),
        .iss_dst   (iss_dst),
        .iss_tag   (iss_tag),
        .cdb_valid (cdb_valid),
        .cdb_tag   (cdb_tag),
        .cdb_data  (cdb_data),
        .tbl_data  (tbl_data),
        .tbl_tag   (tbl_tag)
    );

    assign sel[0] = iss_src_a;
    assign sel[1] = iss_src_b;

    // lookups read the registered table, so they see the pre-rename binding
    for (genvar p = 0; p < SRC_PORTS; p++) begin : g_src
        rat_lookup #(.REG_CNT(REG_CNT), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_lkp (
            .tbl_data  (tbl_data),
            .tbl_tag   (tbl_tag),
            .sel       (sel[p]),
            .cdb_valid (cdb_valid),
            .cdb_tag   (cdb_tag),
            .cdb_data  (cdb_data),
            .rd_data   (rd_data[p]),
            .rd_tag    (rd_tag[p])
        );
    end

    assign src_a_data = rd_data[0];
    assign src_a_tag  = rd_tag[0];
    assign src_b_data = rd_data[1];
    assign src_b_tag  = rd_tag[1];
endmodule

// File: rtl/rat_checker.sv
module rat_checker #(
    parameter int unsigned REG_CNT = 16,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned TAG_W   = 4,
    localparam int unsigned IDX_W  = $clog2(REG_CNT)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              iss_valid,
    input logic [IDX_W-1:0]  iss_dst,
    input logic [TAG_W-1:0]  iss_tag,
    input logic [IDX_W-1:0]  iss_src_a,
    input logic [IDX_W-1:0]  iss_src_b,
    input logic [DATA_W-1:0] src_a_data,
    input logic [TAG_W-1:0]  src_a_tag,
    input logic [DATA_W-1:0] src_b_data,
    input logic [TAG_W-1:0]  src_b_tag,
    input logic              cdb_valid,
    input logic [TAG_W-1:0]  cdb_tag,
    input logic [DATA_W-1:0] cdb_data
);
    a_r3_wait_a_data_zero: assert property (@(posedge clk) disable iff (!rst_n)
        src_a_tag != '0 |-> src_a_data == '0);

    a_r3_wait_b_data_zero: assert property (@(posedge clk) disable iff (!rst_n)
        src_b_tag != '0 |-> src_b_data == '0);

    a_r6_no_tag_during_broadcast: assert property (@(posedge clk) disable iff (!rst_n)
        cdb_valid && cdb_tag != '0 |-> src_a_tag != cdb_tag && src_b_tag != cdb_tag);

    a_r4_rename_seen_next_a: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid && iss_tag != '0 |=>
            (!(iss_src_a == $past(iss_dst) && !(cdb_valid && cdb_tag == $past(iss_tag)))
             || src_a_tag == $past(iss_tag)));

    a_r4_rename_seen_next_b: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid && iss_tag != '0 |=>
            (!(iss_src_b == $past(iss_dst) && !(cdb_valid && cdb_tag == $past(iss_tag)))
             || src_b_tag == $past(iss_tag)));
endmodule

bind rename_table rat_checker #(.REG_CNT(REG_CNT), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_chk (.*);

// File: tb/sim_rename_table.sv
`timescale 1ns/1ps
module sim_rename_table;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        iss_valid = 1'b0;
    logic [3:0]  iss_dst = '0, iss_tag = '0, iss_src_a = '0, iss_src_b = '0;
    logic [31:0] src_a_data, src_b_data;
    logic [3:0]  src_a_tag, src_b_tag;
    logic        cdb_valid = 1'b0;
    logic [3:0]  cdb_tag = '0;
    logic [31:0] cdb_data = '0;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #4 clk = ~clk;   // 125 MHz

    rename_table u0 (.*);

    typedef struct packed {
        logic [7:0]  req;
        logic        iv;
        logic [3:0]  dst, tag, sa, sb;
        logic        cv;
        logic [3:0]  ct;
        logic [31:0] cd;
        logic [3:0]  eat;
        logic [31:0] ead;
        logic [3:0]  ebt;
        logic [31:0] ebd;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{8'd2,  1'b1, 4'd1, 4'd1, 4'd2, 4'd3, 1'b0, 4'd0, 32'h0,  4'd0, 32'h0,  4'd0, 32'h0 },  // R2 ready regs, r1<-t1
        '{8'd6,  1'b0, 4'd0, 4'd0, 4'd1, 4'd1, 1'b1, 4'd1, 32'h11, 4'd0, 32'h11, 4'd0, 32'h11},  // R6 bypass t1
        '{8'd7,  1'b1, 4'd2, 4'd2, 4'd1, 4'd5, 1'b1, 4'd0, 32'h99, 4'd0, 32'h11, 4'd0, 32'h0 },  // R7 written, r2<-t2
        '{8'd4,  1'b1, 4'd3, 4'd3, 4'd2, 4'd2, 1'b0, 4'd0, 32'h0,  4'd2, 32'h0,  4'd2, 32'h0 },  // R4/R3 r2 waits t2
        '{8'd9,  1'b1, 4'd2, 4'd4, 4'd2, 4'd3, 1'b0, 4'd0, 32'h0,  4'd2, 32'h0,  4'd3, 32'h0 },  // R9 src==dst old tag
        '{8'd5,  1'b0, 4'd0, 4'd0, 4'd2, 4'd2, 1'b1, 4'd2, 32'h22, 4'd4, 32'h0,  4'd4, 32'h0 },  // R5 newer tag, stale bus
        '{8'd8,  1'b0, 4'd0, 4'd0, 4'd2, 4'd3, 1'b0, 4'd0, 32'h0,  4'd4, 32'h0,  4'd3, 32'h0 },  // R8 stale ignored
        '{8'd10, 1'b1, 4'd2, 4'd5, 4'd2, 4'd1, 1'b1, 4'd4, 32'h44, 4'd0, 32'h44, 4'd0, 32'h11},  // R10 rename+result
        '{8'd10, 1'b0, 4'd0, 4'd0, 4'd2, 4'd2, 1'b0, 4'd0, 32'h0,  4'd5, 32'h0,  4'd5, 32'h0 },  // R10 new tag kept
        '{8'd11, 1'b1, 4'd4, 4'd0, 4'd4, 4'd1, 1'b0, 4'd0, 32'h0,  4'd0, 32'h0,  4'd0, 32'h11},  // R11 tag-0 issue
        '{8'd11, 1'b0, 4'd0, 4'd0, 4'd4, 4'd4, 1'b0, 4'd0, 32'h0,  4'd0, 32'h0,  4'd0, 32'h0 },  // R11 r4 still ready
        '{8'd6,  1'b0, 4'd0, 4'd0, 4'd2, 4'd3, 1'b1, 4'd5, 32'h55, 4'd0, 32'h55, 4'd3, 32'h0 },  // R6 bypass t5
        '{8'd7,  1'b0, 4'd0, 4'd0, 4'd2, 4'd3, 1'b1, 4'd3, 32'h33, 4'd0, 32'h55, 4'd0, 32'h33},  // R7 r2 value, t3 bypass
        '{8'd7,  1'b0, 4'd0, 4'd0, 4'd3, 4'd2, 1'b0, 4'd0, 32'h0,  4'd0, 32'h33, 4'd0, 32'h55}   // R7 both written
    };

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; iss_valid = 1'b0; cdb_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        do_reset();
        foreach (VECS[i]) begin
            @(negedge clk);
            iss_valid = VECS[i].iv;  iss_dst = VECS[i].dst; iss_tag = VECS[i].tag;
            iss_src_a = VECS[i].sa;  iss_src_b = VECS[i].sb;
            cdb_valid = VECS[i].cv;  cdb_tag = VECS[i].ct;   cdb_data = VECS[i].cd;
            #2;
            begin
                string rq;
                rq = $sformatf("R%0d", VECS[i].req);
                check(rq, $sformatf("vec%0d a_tag", i),  {28'd0, src_a_tag}, {28'd0, VECS[i].eat});
                check(rq, $sformatf("vec%0d a_data", i), src_a_data, VECS[i].ead);
                check(rq, $sformatf("vec%0d b_tag", i),  {28'd0, src_b_tag}, {28'd0, VECS[i].ebt});
                check(rq, $sformatf("vec%0d b_data", i), src_b_data, VECS[i].ebd);
            end
        end

        // R1: reset after activity returns every register to ready, value 0
        do_reset();
        for (int r = 0; r < 16; r++) begin
            @(negedge clk);
            iss_valid = 1'b0; cdb_valid = 1'b0;
            iss_src_a = 4'(r); iss_src_b = 4'(15 - r);
            #2;
            check("R1", $sformatf("reg%0d tag", r),  {28'd0, src_a_tag}, 32'd0);
            check("R1", $sformatf("reg%0d data", r), src_a_data, 32'd0);
        end

        // R7: broadcast with tag 0 must not write ready registers
        @(negedge clk);
        cdb_valid = 1'b1; cdb_tag = 4'd0; cdb_data = 32'hDEAD;
        @(negedge clk);
        cdb_valid = 1'b0; iss_src_a = 4'd0; iss_src_b = 4'd9;
        #2;
        check("R7", "tag0 bus reg0", src_a_data, 32'd0);
        check("R7", "tag0 bus reg9", src_b_data, 32'd0);

        // R4/R2: rename r9 to t15, then release it with a value
        @(negedge clk);
        iss_valid = 1'b1; iss_dst = 4'd9; iss_tag = 4'd15;
        @(negedge clk);
        iss_valid = 1'b0; cdb_valid = 1'b1; cdb_tag = 4'd15; cdb_data = 32'hCAFE;
        @(negedge clk);
        cdb_valid = 1'b0; iss_src_a = 4'd9;
        #2;
        check("R2", "r9 ready tag", {28'd0, src_a_tag}, 32'd0);
        check("R2", "r9 value", src_a_data, 32'hCAFE);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule